// File: doc/BRIEF.md
# Packed-Field Real-Time Counter with Alarms

This block keeps wall-clock time at one-second resolution in a single 32-bit word. The word holds a second field, a minute field, an hour field and a 15-bit day count. It is clocked from a 32.768 kHz source. When the prescaler is on, a divider advances the count once per second. When the prescaler is off, the count advances on every slow-clock cycle, which is useful for test and fast bring-up.

On every advance the block compares the new count against an alarm word and raises sticky status flags:
- one flag per second increment;
- one flag per rollover of minutes, hours and days;
- a time-of-day alarm flag, which ignores the day field;
- a full-word alarm flag, which compares all 32 bits.

An enable mask selects which flags drive the single interrupt line. Software clears flags by writing ones to them.

New time and alarm values are not applied at once. A load is captured into a holding register, and a write-pending flag stays up until the next advance, where the value takes effect and a write-complete flag is raised. A load offered while an earlier one is still pending is dropped.

Top module: `rtc_packed_counter`

## Requirements
- R1: After reset the time word is 0, the alarm word is 0, all status bits are 0 and `irq_o` is 0.
- R2: The time word is {day[31:17], hour[16:12], minute[11:6], second[5:0]}. Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap carries into the next field, and the day field wraps from 32767 to 0.
- R3: With `presc_en_i` high the count advances once every 32768 clock cycles. With it low the count advances on every cycle. Between advances the time word does not change.
- R4: On an increment, status bit 2 is set. Bit 3 is set when seconds wrap, bit 4 when minutes wrap, and bit 5 when hours wrap (the day increments). A day wrap sets no extra bit.
- R5: Status bit 1 is set on an advance after which the hour, minute and second fields of the time equal those of the alarm word.
- R6: Status bit 6 is set on an advance after which all 32 bits of time and alarm are equal. Each match sets its bit once per advance, so a bit cleared during a matching second stays clear until the next advance.
- R7: Status bits are set whether or not they are enabled. `irq_o` is high exactly when some status bit and the same bit of `irq_en_i` are both 1.
- R8: A 1 in `stat_clr_i` clears the matching sticky status bit on the next edge. A set in the same cycle takes priority over the clear.
- R9: A load pulse with no write pending is captured, and status bit 14 reads 1 until the next advance. At that advance the captured value replaces the time (instead of incrementing) or the alarm, bit 14 falls and bit 15 is set. Loads offered while bit 14 is 1 are ignored.
- R10: Status bits 0 and 7 to 13 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz counting clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| presc_en_i | input | 1 | 1: advance once per 32768 cycles; 0: advance every cycle |
| time_ld_i | input | 1 | Load pulse for the time word |
| time_val_i | input | 32 | Time value to load |
| alarm_ld_i | input | 1 | Load pulse for the alarm word |
| alarm_val_i | input | 32 | Alarm value to load |
| irq_en_i | input | 16 | Per-flag interrupt enable mask |
| stat_clr_i | input | 16 | Write-one-to-clear mask for status flags |
| time_o | output | 32 | Current packed time word |
| stat_o | output | 16 | Status flags |
| irq_o | output | 1 | Interrupt, OR of enabled set flags |

## Verification
The counter is driven through loaded start points that sit just before a minute, hour and day boundary, and through the all-ones day boundary. These separate the carry chain from the day wrap. Alarm words are chosen to match on time of day but not day, and then on the full word, which tells the two alarm flags apart. A prescaled run pairs two back-to-back loads with a cleared flag in the middle of a matching second. That run distinguishes dropped loads, a one-second advance interval and a match that sets its flag only once. A behavioural model is compared against the outputs on every cycle, including `irq_o` under changing enable masks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 15;
  localparam int TIME_W = SEC_W + MIN_W + HR_W + DAY_W;

  localparam int SEC_LIM = 60;
  localparam int MIN_LIM = 60;
  localparam int HR_LIM  = 24;

  localparam int STAT_W = 16;
  localparam int FL_ALM   = 1;
  localparam int FL_SEC   = 2;
  localparam int FL_MIN   = 3;
  localparam int FL_HR    = 4;
  localparam int FL_DAY   = 5;
  localparam int FL_DALM  = 6;
  localparam int FL_WPEND = 14;
  localparam int FL_WDONE = 15;

  typedef struct packed {
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] mn;
    logic [SEC_W-1:0] sc;
  } rtc_time_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CNT_W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign tick_o = en_i ? (&cnt_q) : 1'b1;

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_o) |=> (!en_i || !tick_o)); // R3
endmodule

// File: rtl/rtc_time_adv.sv
module rtc_time_adv
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  output rtc_time_t nxt_o,
  output logic      sec_wrap_o,
  output logic      min_wrap_o,
  output logic      hr_wrap_o
);
  always_comb begin
    nxt_o      = cur_i;
    sec_wrap_o = (cur_i.sc >= SEC_W'(SEC_LIM - 1));
    min_wrap_o = sec_wrap_o && (cur_i.mn >= MIN_W'(MIN_LIM - 1));
    hr_wrap_o  = min_wrap_o && (cur_i.hr >= HR_W'(HR_LIM - 1));
    nxt_o.sc   = sec_wrap_o ? '0 : cur_i.sc + 1'b1;
    if (sec_wrap_o) nxt_o.mn = min_wrap_o ? '0 : cur_i.mn + 1'b1;
    if (min_wrap_o) nxt_o.hr = hr_wrap_o ? '0 : cur_i.hr + 1'b1;
    if (hr_wrap_o)  nxt_o.day = cur_i.day + 1'b1; // wraps at all-ones
  end
endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [STAT_W-1:0] ev_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic              pend_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q, set_w;

  assign set_w = tick_i ? ev_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | set_w; // set wins
  end

  always_comb begin
    stat_o           = stat_q;
    stat_o[FL_WPEND] = pend_i;
  end

  AST_SET_ON_TICK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ((stat_q & ~$past(stat_q)) == '0)); // R4
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[13:7] == '0) && !stat_o[0]); // R10
endmodule

// File: rtl/rtc_packed_counter.sv
module rtc_packed_counter
  import rtc_pkg::*;
#(
  parameter int PRESC_W = 15
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        presc_en_i,
  input  logic        time_ld_i,
  input  logic [31:0] time_val_i,
  input  logic        alarm_ld_i,
  input  logic [31:0] alarm_val_i,
  input  logic [15:0] irq_en_i,
  input  logic [15:0] stat_clr_i,
  output logic [31:0] time_o,
  output logic [15:0] stat_o,
  output logic        irq_o
);
  logic      tick, pend;
  logic      t_vld_q, a_vld_q;
  rtc_time_t t_shd_q, a_shd_q, time_q, alarm_q;
  rtc_time_t adv, time_nxt, alarm_nxt;
  logic      sec_wrap, min_wrap, hr_wrap;
  logic [STAT_W-1:0] ev;

  rtc_prescaler #(.CNT_W(PRESC_W)) u_presc (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(presc_en_i), .tick_o(tick)
  );

  rtc_time_adv u_adv (
    .cur_i(time_q), .nxt_o(adv),
    .sec_wrap_o(sec_wrap), .min_wrap_o(min_wrap), .hr_wrap_o(hr_wrap)
  );

  assign pend = t_vld_q | a_vld_q;

  // holding registers: accept only when nothing is pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_vld_q <= 1'b0; t_shd_q <= '0;
      a_vld_q <= 1'b0; a_shd_q <= '0;
    end else begin
      if (!pend && time_ld_i) begin
        t_vld_q <= 1'b1; t_shd_q <= time_val_i;
      end else if (tick) t_vld_q <= 1'b0;
      if (!pend && alarm_ld_i) begin
        a_vld_q <= 1'b1; a_shd_q <= alarm_val_i;
      end else if (tick) a_vld_q <= 1'b0;
    end
  end

  assign time_nxt  = t_vld_q ? t_shd_q : adv;
  assign alarm_nxt = a_vld_q ? a_shd_q : alarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q  <= '0;
      alarm_q <= '0;
    end else if (tick) begin
      time_q  <= time_nxt;
      alarm_q <= alarm_nxt;
    end
  end

  always_comb begin
    ev           = '0;
    ev[FL_SEC]   = !t_vld_q;
    ev[FL_MIN]   = !t_vld_q && sec_wrap;
    ev[FL_HR]    = !t_vld_q && min_wrap;
    ev[FL_DAY]   = !t_vld_q && hr_wrap;
    ev[FL_ALM]   = (time_nxt.hr == alarm_nxt.hr) && (time_nxt.mn == alarm_nxt.mn)
                   && (time_nxt.sc == alarm_nxt.sc);
    ev[FL_DALM]  = (time_nxt == alarm_nxt);
    ev[FL_WDONE] = pend;
  end

  rtc_event_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .ev_i(ev),
    .clr_i(stat_clr_i), .pend_i(pend), .stat_o(stat_o)
  );

  assign time_o = time_q;
  assign irq_o  = |(stat_o & irq_en_i);

  AST_TIME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(time_o)); // R3
  AST_SHADOW_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |=> ($stable(t_shd_q) && $stable(a_shd_q))); // R9
  AST_WDONE_ON_APPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && tick) |=> (stat_o[FL_WDONE] && !stat_o[FL_WPEND])); // R9
endmodule

// File: tb/rtc_packed_counter_test.sv
`timescale 1ns/100ps
module rtc_packed_counter_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        pe = 1'b0, tl = 1'b0, al = 1'b0;
  logic [31:0] tv = '0, av = '0;
  logic [15:0] ien = '0, clr = '0;
  logic [31:0] time_o;
  logic [15:0] stat_o;
  logic        irq_o;
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_packed_counter uut (
    .clk_i(clk), .rst_ni(rst_n), .presc_en_i(pe),
    .time_ld_i(tl), .time_val_i(tv), .alarm_ld_i(al), .alarm_val_i(av),
    .irq_en_i(ien), .stat_clr_i(clr),
    .time_o(time_o), .stat_o(stat_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] pk(int d, int h, int m, int s);
    return {d[14:0], h[4:0], m[5:0], s[5:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int pc;
  bit m_tv, m_av;
  logic [31:0] m_ts, m_as, m_time, m_alm;
  logic [15:0] m_st;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc = 0; m_tv = 0; m_av = 0; m_ts = 0; m_as = 0;
      m_time = 0; m_alm = 0; m_st = 0;
    end else begin
      bit tick, pend, ntv, nav;
      logic [15:0] set;
      logic [31:0] nt, na;
      int s, m, h, d;
      tick = pe ? (pc == 32767) : 1'b1;
      pc   = pe ? (pc + 1) % 32768 : 0;
      pend = m_tv | m_av;
      set  = 0;
      if (tick) begin
        if (m_tv) nt = m_ts;
        else begin
          s = int'(m_time[5:0]); m = int'(m_time[11:6]);
          h = int'(m_time[16:12]); d = int'(m_time[31:17]);
          set[2] = 1; s++;
          if (s == 60) begin
            s = 0; set[3] = 1; m++;
            if (m == 60) begin
              m = 0; set[4] = 1; h++;
              if (h == 24) begin h = 0; set[5] = 1; d = (d + 1) % 32768; end
            end
          end
          nt = pk(d, h, m, s);
        end
        na = m_av ? m_as : m_alm;
        if (nt[16:0] == na[16:0]) set[1] = 1;
        if (nt == na) set[6] = 1;
        if (pend) set[15] = 1;
        m_time = nt; m_alm = na;
      end
      ntv = m_tv; nav = m_av;
      if (!pend && tl) begin m_ts = tv; ntv = 1; end else if (tick) ntv = 0;
      if (!pend && al) begin m_as = av; nav = 1; end else if (tick) nav = 0;
      m_tv = ntv; m_av = nav;
      m_st = (m_st & ~clr & 16'hBFFF) | set;
      m_st[14] = ntv | nav;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 time word", time_o, m_time);
      chk("R4 status", {16'h0, stat_o}, {16'h0, m_st});
      chk("R7 irq", {31'h0, irq_o}, {31'h0, |(m_st & ien)});
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    logic [31:0] t0;
    step(); step();
    chk("R1 time", time_o, 32'h0);
    chk("R1 stat", {16'h0, stat_o}, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    rst_n = 1'b1;

    // carry chain, free-running mode
    tl = 1; tv = pk(5, 23, 59, 58); clr = 16'hFFFF;
    step(); tl = 0; clr = 0;
    chk("R9 pending", {31'h0, stat_o[14]}, 32'h1);
    step();
    chk("R9 applied", time_o, pk(5, 23, 59, 58));
    chk("R9 complete", {31'h0, stat_o[15]}, 32'h1);
    clr = 16'hFFFF; step(); clr = 0;
    chk("R4 sec only", {16'h0, stat_o}, 32'h0004);
    step();
    chk("R2 day carry", time_o, pk(6, 0, 0, 0));
    chk("R4 R5 rollover flags", {16'h0, stat_o}, 32'h003E);

    // day wrap
    tl = 1; tv = pk(32767, 23, 59, 59); step(); tl = 0; step();
    clr = 16'hFFFF; step(); clr = 0;
    chk("R2 day wrap", time_o, 32'h0);
    chk("R6 full match", {16'h0, stat_o}, 32'h007E);
    chk("R7 disabled irq", {31'h0, irq_o}, 32'h0);
    ien = 16'h0040; #1;
    chk("R7 enabled irq", {31'h0, irq_o}, 32'h1);
    clr = 16'h0040; step(); clr = 0;
    chk("R8 cleared", {31'h0, stat_o[6]}, 32'h0);
    chk("R8 irq low", {31'h0, irq_o}, 32'h0);
    chk("R10 unused", {16'h0, stat_o & 16'h3F81}, 32'h0);

    // time-of-day alarm vs full-word alarm
    ien = 16'h0002;
    tl = 1; tv = pk(2, 0, 0, 0); al = 1; av = pk(9, 0, 0, 3);
    step(); tl = 0; al = 0; step();
    step(); clr = 16'hFFFF; step(); clr = 0; step();
    chk("R5 time", time_o, pk(2, 0, 0, 3));
    chk("R5 hms alarm", {31'h0, stat_o[1]}, 32'h1);
    chk("R6 no full match", {31'h0, stat_o[6]}, 32'h0);
    chk("R7 irq alarm", {31'h0, irq_o}, 32'h1);

    // prescaled: dropped second load, one-second spacing, single match
    pe = 1; tl = 1; tv = pk(1, 0, 0, 10); al = 1; av = pk(1, 0, 0, 11);
    step(); tl = 0; al = 0;
    tl = 1; tv = pk(7, 7, 7, 7); step(); tl = 0;
    n = 0;
    while (stat_o[14] && n < 40000) begin step(); n++; end
    chk("R9 second load ignored", time_o, pk(1, 0, 0, 10));
    t0 = time_o; n = 0;
    while (time_o == t0 && n < 40000) begin step(); n++; end
    chk("R3 prescaled interval", n, 32768);
    chk("R6 time", time_o, pk(1, 0, 0, 11));
    chk("R6 full match set", {31'h0, stat_o[6]}, 32'h1);
    clr = 16'h0042; step(); clr = 0;
    for (int i = 0; i < 1000; i++) step();
    chk("R6 once per tick", {16'h0, stat_o & 16'h0042}, 32'h0);
    finish_run();
  end
endmodule